// File: doc/BRIEF.md
# Asynchronous Static RAM Bridge

This block connects a synchronous request bus to an external asynchronous static RAM of 524,288 words by 16 bits. A client offers one request at a time with a valid/ready handshake. Each request carries a word address, write data, a read/write flag and a two-bit lane mask. The bridge then generates the memory pins with the timing the part needs: setup before the write strobe falls, a strobe or read wait long enough for the selected speed grade, and a hold cycle after the strobe rises. It finishes every request with a one-cycle done pulse that carries read data.

The memory is selected only when its active-low select is low and its active-high select is high at the same time. Between accesses the bridge parks both selects in the deselected state and raises both byte enables, which holds the part in standby. The access wait is derived at elaboration from two parameters, the access time and the clock period. It is the ceiling of their ratio: 14 cycles at the default of 70 ns and 5 ns.

Top module: `sram_bridge`

## Requirements
- R1: After reset, and whenever no request is in progress: memCe1N=1, memCe2=0, memWeN=1, memOeN=1, memUbN=1, memLbN=1, memDqOe=0, reqReady=1 and doneValid=0.
- R2: A write presents address, lane enables and data with the chip selected and memWeN high for one setup cycle. It then holds memWeN low for exactly WAIT_CYC cycles, then keeps address, data and select for one hold cycle with memWeN high.
- R3: memOeN stays high for the whole of a write. memDqOe is high only in the setup, strobe and hold cycles of a write, so the bridge never drives the bus while memOeN is low.
- R4: Lane mask bit 0 selects data bits 7:0 and drives memLbN low during the access. Bit 1 selects bits 15:8 and drives memUbN low. A lane whose mask bit is 0 keeps its enable high and is neither written nor read.
- R5: A read keeps the chip selected with memOeN low, memWeN high and memDqOe low for exactly WAIT_CYC cycles.
- R6: A read samples memDqIn on its last wait cycle. doneRdata carries the requested lanes and zero in lanes not requested. A write returns doneRdata of zero.
- R7: A request with lane mask 00 completes with doneValid in the cycle after acceptance and never selects the memory. A write with mask 00 leaves memory contents unchanged.
- R8: reqReady is high only when the bridge is idle, so a second request is not accepted before the done pulse. doneValid lasts exactly one cycle.
- R9: Counting the cycle after the accepting edge as cycle 1, done rises in cycle WAIT_CYC+3 for a write and in cycle WAIT_CYC+1 for a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Bridge idle, request accepted on this edge if valid |
| reqWrite | input | 1 | 1 for write, 0 for read |
| reqAddr | input | 19 | Word address |
| reqWdata | input | 16 | Write data |
| reqLanes | input | 2 | Lane mask, bit 0 low byte, bit 1 high byte |
| doneValid | output | 1 | One-cycle completion pulse |
| doneRdata | output | 16 | Read data, unrequested lanes zero |
| memCe1N | output | 1 | Active-low chip select |
| memCe2 | output | 1 | Active-high chip select |
| memWeN | output | 1 | Active-low write strobe |
| memOeN | output | 1 | Active-low output enable |
| memUbN | output | 1 | Active-low enable for bits 15:8 |
| memLbN | output | 1 | Active-low enable for bits 7:0 |
| memAddr | output | 19 | Memory address |
| memDqOut | output | 16 | Data driven toward memory |
| memDqOe | output | 1 | Bridge drives the data bus |
| memDqIn | input | 16 | Data returned from memory |

## Verification
Every result is timed from the accepting clock edge. Done is due WAIT_CYC+3 cycles after it for writes, WAIT_CYC+1 for reads and 1 cycle for an empty mask. reqReady must be low in the first cycle after acceptance and high again the cycle after done. Each scenario task drives inputs on the falling edge and counts falling-edge samples from acceptance until done, so it compares the measured latency with those counts. A pin monitor accumulates select, strobe and lane activity at rising edges. This shows the strobe width, lane use and the memory untouched by empty requests.

// File: rtl/sram_bridge_pkg.sv
package sram_bridge_pkg;
  localparam int LANES  = 2;
  localparam int LANE_W = 8;
  localparam int DATA_W = LANES * LANE_W;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_STROBE, ST_HOLD, ST_ACCESS, ST_FINISH
  } bridgeState_t;

  typedef struct packed {
    logic load;     // latch request into datapath
    logic select;   // memory chip selected
    logic weLow;    // write strobe active
    logic oeLow;    // output enable active
    logic drive;    // bridge owns the data bus
    logic capture;  // sample read data
  } ctlStrobe_t;
endpackage

// File: rtl/sram_bridge_ctrl.sv
module sram_bridge_ctrl
  import sram_bridge_pkg::*;
#(
  parameter int WAIT_CYC = 14
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic [LANES-1:0] reqLanes,
  output logic             reqReady,
  output logic             doneValid,
  output ctlStrobe_t       ctl
);
  localparam int CNT_W = $clog2(WAIT_CYC + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WAIT_CYC - 1);

  bridgeState_t state;
  logic [CNT_W-1:0] cnt;
  logic lastWait;

  assign lastWait = (cnt == LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          cnt <= '0;
          if (reqValid) begin
            if (reqLanes == '0) state <= ST_FINISH;
            else if (reqWrite)  state <= ST_SETUP;
            else                state <= ST_ACCESS;
          end
        end
        ST_SETUP: state <= ST_STROBE;
        ST_STROBE, ST_ACCESS: begin
          if (lastWait) begin
            cnt   <= '0;
            state <= (state == ST_STROBE) ? ST_HOLD : ST_FINISH;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_HOLD:   state <= ST_FINISH;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    reqReady    = (state == ST_IDLE);
    doneValid   = (state == ST_FINISH);
    ctl.load    = reqReady && reqValid;
    ctl.drive   = (state == ST_SETUP) || (state == ST_STROBE) || (state == ST_HOLD);
    ctl.select  = ctl.drive || (state == ST_ACCESS);
    ctl.weLow   = (state == ST_STROBE);
    ctl.oeLow   = (state == ST_ACCESS);
    ctl.capture = (state == ST_ACCESS) && lastWait;
  end
endmodule

// File: rtl/sram_bridge_dp.sv
module sram_bridge_dp
  import sram_bridge_pkg::*;
#(
  parameter int ADDR_W = 19
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        ctl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [LANES-1:0]  reqLanes,
  input  logic [DATA_W-1:0] memDqIn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDqOut,
  output logic [LANES-1:0]  laneEnN,
  output logic [DATA_W-1:0] doneRdata
);
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [LANES-1:0]  lanesQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      lanesQ <= '0;
    end else if (ctl.load) begin
      addrQ  <= reqAddr;
      wdataQ <= reqWdata;
      lanesQ <= reqLanes;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        doneRdata[g*LANE_W +: LANE_W] <= '0;
      else if (ctl.load)
        doneRdata[g*LANE_W +: LANE_W] <= '0;
      else if (ctl.capture)
        doneRdata[g*LANE_W +: LANE_W] <= lanesQ[g] ? memDqIn[g*LANE_W +: LANE_W] : '0;
    end
    assign laneEnN[g] = ~(ctl.select & lanesQ[g]);
  end

  assign memAddr  = addrQ;
  assign memDqOut = wdataQ;
endmodule

// File: rtl/sram_bridge.sv
module sram_bridge
  import sram_bridge_pkg::*;
#(
  parameter int ADDR_W    = 19,
  parameter int ACCESS_NS = 70,
  parameter int CLK_NS    = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [15:0]       reqWdata,
  input  logic [1:0]        reqLanes,
  output logic              doneValid,
  output logic [15:0]       doneRdata,
  output logic              memCe1N,
  output logic              memCe2,
  output logic              memWeN,
  output logic              memOeN,
  output logic              memUbN,
  output logic              memLbN,
  output logic [ADDR_W-1:0] memAddr,
  output logic [15:0]       memDqOut,
  output logic              memDqOe,
  input  logic [15:0]       memDqIn
);
  localparam int WAIT_CYC = (ACCESS_NS + CLK_NS - 1) / CLK_NS;

  ctlStrobe_t ctl;
  logic [LANES-1:0] laneEnN;

  sram_bridge_ctrl #(.WAIT_CYC(WAIT_CYC)) i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqLanes(reqLanes), .reqReady(reqReady), .doneValid(doneValid), .ctl(ctl)
  );

  sram_bridge_dp #(.ADDR_W(ADDR_W)) i_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .reqLanes(reqLanes), .memDqIn(memDqIn), .memAddr(memAddr),
    .memDqOut(memDqOut), .laneEnN(laneEnN), .doneRdata(doneRdata)
  );

  assign memCe1N = ~ctl.select;
  assign memCe2  = ctl.select;
  assign memWeN  = ~ctl.weLow;
  assign memOeN  = ~ctl.oeLow;
  assign memDqOe = ctl.drive;
  assign memLbN  = laneEnN[0];
  assign memUbN  = laneEnN[1];
endmodule

// File: rtl/sram_bridge_chk.sv
module sram_bridge_chk #(
  parameter int ADDR_W   = 19,
  parameter int WAIT_CYC = 14
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              doneValid,
  input logic              memCe1N,
  input logic              memCe2,
  input logic              memWeN,
  input logic              memOeN,
  input logic              memUbN,
  input logic              memLbN,
  input logic [ADDR_W-1:0] memAddr,
  input logic [15:0]       memDqOut,
  input logic              memDqOe
);
  logic [15:0] lowCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        lowCnt <= '0;
    else if (!memWeN) lowCnt <= lowCnt + 1'b1;
    else              lowCnt <= '0;
  end

  a_r2_strobe_width: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> lowCnt == 16'(WAIT_CYC));
  a_r2_strobe_selected: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> (!memCe1N && memCe2 && memDqOe));
  a_r2_setup: assert property (@(posedge clk) disable iff (!rstN)
    $fell(memWeN) |-> ($stable(memAddr) && $stable(memDqOut) && $stable(memUbN)
                       && $stable(memLbN) && $past(memDqOe) && $past(!memCe1N)));
  a_r2_hold: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> (memDqOe && !memCe1N && $stable(memAddr) && $stable(memDqOut)));
  a_r3_oe_high_in_write: assert property (@(posedge clk) disable iff (!rstN)
    memDqOe |-> memOeN);
  a_r5_read_quiet_bus: assert property (@(posedge clk) disable iff (!rstN)
    !memOeN |-> (memWeN && !memDqOe && !memCe1N && memCe2));
  a_r8_idle_parked: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (memCe1N && !memCe2 && memUbN && memLbN && !memDqOe));
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);
  a_r8_busy_not_ready: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);
endmodule

bind sram_bridge sram_bridge_chk #(.ADDR_W(ADDR_W), .WAIT_CYC(WAIT_CYC)) i_chk (.*);

// File: tb/test_sram_bridge.sv
module test_sram_bridge;
  localparam int W = 14;  // ceil(70 / 5)

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [18:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic [1:0] reqLanes = '0;
  logic reqReady, doneValid, memCe1N, memCe2, memWeN, memOeN, memUbN, memLbN, memDqOe;
  logic [15:0] doneRdata, memDqOut, memDqIn;
  logic [18:0] memAddr;

  int checks = 0, failures = 0;
  logic [15:0] mem [64];
  int selCnt = 0, weLowCnt = 0, clash = 0;
  logic ubSeen = 0, lbSeen = 0;
  logic [18:0] lastAddr = '0;
  logic [15:0] gotData;
  int gotLat;

  always #2.5 clk = ~clk;

  sram_bridge i_sram_bridge (.*);

  wire sel = !memCe1N && memCe2;
  assign memDqIn = (sel && !memOeN) ?
    {memUbN ? 8'hA5 : mem[memAddr[5:0]][15:8], memLbN ? 8'h5A : mem[memAddr[5:0]][7:0]} : 16'hFFFF;

  always @(posedge clk) begin
    if (sel) begin
      selCnt++;
      lastAddr <= memAddr;
      if (!memUbN) ubSeen <= 1;
      if (!memLbN) lbSeen <= 1;
      if (!memWeN) begin
        weLowCnt++;
        if (!memUbN) mem[memAddr[5:0]][15:8] <= memDqOut[15:8];
        if (!memLbN) mem[memAddr[5:0]][7:0]  <= memDqOut[7:0];
      end
    end
    if (!memOeN && memDqOe) clash++;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doReq(logic wr, logic [18:0] a, logic [15:0] d, logic [1:0] ln);
    @(negedge clk);
    selCnt = 0; weLowCnt = 0; ubSeen = 0; lbSeen = 0;
    reqValid = 1; reqWrite = wr; reqAddr = a; reqWdata = d; reqLanes = ln;
    @(negedge clk);
    reqValid = 0;
    check("R8 busy ready low", reqReady, 0);
    gotLat = 1;
    while (!doneValid && gotLat < 200) begin
      @(negedge clk);
      gotLat++;
    end
    gotData = doneRdata;
    @(negedge clk);
    check("R8 done one cycle", doneValid, 0);
    check("R1 idle ready", reqReady, 1);
    check("R1 parked select", {memCe1N, memCe2, memUbN, memLbN}, 4'b1011);
  endtask

  task automatic tWriteFull();
    doReq(1, 19'h00005, 16'hBEEF, 2'b11);
    check("R9 write latency", gotLat, W + 3);
    check("R2 strobe width", weLowCnt, W);
    check("R2 stored word", mem[5], 16'hBEEF);
    check("R2 address", lastAddr, 19'h00005);
    check("R6 write rdata zero", gotData, 0);
    check("R3 no clash", clash, 0);
  endtask

  task automatic tReadFull();
    doReq(0, 19'h00005, 16'h0, 2'b11);
    check("R9 read latency", gotLat, W + 1);
    check("R5 read no strobe", weLowCnt, 0);
    check("R6 read word", gotData, 16'hBEEF);
  endtask

  task automatic tLanes();
    doReq(1, 19'h00005, 16'h1234, 2'b01);
    check("R4 low lane write", mem[5], 16'hBE34);
    check("R4 high enable unused", {ubSeen, lbSeen}, 2'b01);
    doReq(1, 19'h00005, 16'h7700, 2'b10);
    check("R4 high lane write", mem[5], 16'h7734);
    doReq(0, 19'h00005, 16'h0, 2'b10);
    check("R6 high lane read", gotData, 16'h7700);
    doReq(0, 19'h00005, 16'h0, 2'b01);
    check("R6 low lane read", gotData, 16'h0034);
  endtask

  task automatic tEmpty();
    doReq(1, 19'h00005, 16'hFFFF, 2'b00);
    check("R7 empty latency", gotLat, 1);
    check("R7 no select", selCnt, 0);
    check("R7 memory unchanged", mem[5], 16'h7734);
    doReq(0, 19'h00005, 16'h0, 2'b00);
    check("R7 empty read data", gotData, 0);
  endtask

  task automatic tTopAddr();
    doReq(1, 19'h7FFFF, 16'hC3C3, 2'b11);
    check("R2 top address", lastAddr, 19'h7FFFF);
    doReq(0, 19'h7FFFF, 16'h0, 2'b11);
    check("R6 top address read", gotData, 16'hC3C3);
    check("R3 no clash end", clash, 0);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    check("R1 reset select", {memCe1N, memCe2, memWeN, memOeN}, 4'b1011);
    check("R1 reset lanes", {memUbN, memLbN, memDqOe}, 3'b110);
    check("R1 reset ready done", {reqReady, doneValid}, 2'b10);
    rstN = 1;
    tWriteFull();
    tReadFull();
    tLanes();
    tEmpty();
    tTopAddr();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule